// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block protects a shared address/data bus and its command/byte-lane bus with one even-parity bit. Whenever the local agent owns the bus, the block generates the parity bit for the values it drove. That bit appears one clock after those values. Whenever another agent owns the bus, the block checks the incoming parity bit against the values seen one clock earlier. The even-parity rule is that the data bits, the lane bits and the parity bit together hold an even number of ones.

A mismatch is reported according to the kind of transfer it was found in. An error during an address transfer is a system error and drives the system-error pulse. An error during a completed data transfer drives the data-error pulse. Each pulse has its own enable bit. Two sticky status bits record what happened: one records any detected parity error, and one records any system error that was signalled. Software clears each status bit by writing a one to it.

The block does not sequence the bus protocol. The surrounding logic tells it, in each clock, whether an address transfer is being sampled, whether a data transfer has completed, and whether the local agent is driving. The block carries no streaming payload, so every pin is a plain level or strobe and none of them uses a valid/ready handshake.

Top module: `bus_parity_unit`

## Requirements
- R1: When `own_drive` is high at a rising edge, `chk_bit_oe` is high during the following clock. In that clock, `chk_bit_out` equals the XOR of the `addr_data` and `cmd_lane` bits sampled at that edge. When `own_drive` was low at the edge, `chk_bit_oe` is low.
- R2: While `rst_n` is low, `chk_bit_oe`, both error pulses and both status bits are low, whatever the other inputs do.
- R3: A data transfer is one sampled with `data_strobe` high and `addr_strobe` low. Suppose one is sampled at edge k. If the XOR of its bus bits and of `chk_bit_in` sampled at edge k+1 is one, and `data_err_en` is high at edge k+1, then `data_err_pulse` is high for exactly the clock after edge k+1.
- R4: A cycle with both `addr_strobe` and `data_strobe` low is never checked, whatever the parity.
- R5: An address transfer is one sampled with `addr_strobe` high. If it carries a parity mismatch, found with the same one-clock-later rule, and `sys_err_en` is high, then `sys_err_pulse` is high for one clock after edge k+1. `data_err_pulse` stays low in that case.
- R6: When `data_err_en` is low, `data_err_pulse` stays low. When `sys_err_en` is low, `sys_err_pulse` stays low.
- R7: A cycle sampled with `own_drive` high is never checked and raises no error or status bit.
- R8: `parity_seen_sts` sets on any detected mismatch, whether in an address or a data transfer and whatever the enables are. `sys_err_sts` sets whenever `sys_err_pulse` is raised. Each status bit holds until its clear strobe is sampled high, and a new set in the same clock wins over the clear.
- R9: When `addr_strobe` and `data_strobe` are both high, the transfer is treated as an address transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| addr_data | input | DATA_W | Address/data bus value seen on the bus |
| cmd_lane | input | CMD_W | Command/byte-lane bus value seen on the bus |
| chk_bit_in | input | 1 | Received parity bit, covering the previous clock's bus values |
| addr_strobe | input | 1 | Current cycle is an address transfer |
| data_strobe | input | 1 | Current cycle is a completed data transfer |
| own_drive | input | 1 | Local agent drives the bus in this cycle |
| data_err_en | input | 1 | Enable for data-transfer error reporting |
| sys_err_en | input | 1 | Enable for address-transfer system-error reporting |
| parity_seen_clr | input | 1 | Write-one strobe that clears `parity_seen_sts` |
| sys_err_clr | input | 1 | Write-one strobe that clears `sys_err_sts` |
| chk_bit_out | output | 1 | Generated parity bit |
| chk_bit_oe | output | 1 | Output enable for `chk_bit_out` |
| data_err_pulse | output | 1 | One-clock data parity error report |
| sys_err_pulse | output | 1 | One-clock system error report |
| parity_seen_sts | output | 1 | Sticky detected-parity-error flag |
| sys_err_sts | output | 1 | Sticky signalled-system-error flag |

## Verification
The bench builds the block with `DATA_W` = 8 and `CMD_W` = 2, so the parity tree covers 10 bus bits plus the check bit. At that size every one of the 1024 bus values can be run with both values of the received parity bit. Each of those 2048 transfers gets a rotating mix of address, data, idle and own-drive cycles and of enable settings. Every corner of the routing and suppression rules is therefore met against many parity outcomes. Separate sequences cover reset, status stickiness, and a clear that arrives together with a new error.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Address sampling outranks data completion; an own-drive cycle is never checked.
  function automatic phase_e classify(input logic addr_s, input logic data_s,
                                      input logic own);
    phase_e k;
    if (own)         k = PH_IDLE;
    else if (addr_s) k = PH_ADDR;
    else if (data_s) k = PH_DATA;
    else             k = PH_IDLE;
    return k;
  endfunction

endpackage

// File: rtl/bpar_xor_tree.sv
module bpar_xor_tree #(
  parameter int W = 37
) (
  input  logic [W-1:0] bits_in,
  output logic         odd_out
);
  localparam int LEVELS = (W > 1) ? $clog2(W) : 0;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  genvar i;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < W) begin : g_used
        assign node[LEAVES-1+i] = bits_in[i];
      end else begin : g_pad
        assign node[LEAVES-1+i] = 1'b0;
      end
    end
    for (i = 0; i < LEAVES - 1; i++) begin : g_inner
      assign node[i] = node[2*i+1] ^ node[2*i+2];
    end
  endgenerate

  assign odd_out = node[0];
endmodule

// File: rtl/bpar_capture.sv
module bpar_capture
  import bpar_pkg::*;
#(
  parameter int BUS_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             addr_strobe,
  input  logic             data_strobe,
  input  logic             own_drive,
  output logic [BUS_W-1:0] bus_q,
  output phase_e           kind_q,
  output logic             drive_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '0;
      kind_q  <= PH_IDLE;
      drive_q <= 1'b0;
    end else begin
      bus_q   <= bus_in;
      kind_q  <= classify(addr_strobe, data_strobe, own_drive);
      drive_q <= own_drive;
    end
  end

  // R7
  own_drive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_drive |=> (kind_q == PH_IDLE));

endmodule

// File: rtl/bpar_report.sv
module bpar_report
  import bpar_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e kind_q,
  input  logic   mismatch,
  input  logic   data_err_en,
  input  logic   sys_err_en,
  input  logic   parity_seen_clr,
  input  logic   sys_err_clr,
  output logic   data_err_pulse,
  output logic   sys_err_pulse,
  output logic   parity_seen_sts,
  output logic   sys_err_sts
);
  logic bad_addr, bad_data, sys_fire;

  assign bad_addr = (kind_q == PH_ADDR) && mismatch;
  assign bad_data = (kind_q == PH_DATA) && mismatch;
  assign sys_fire = bad_addr && sys_err_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_err_pulse  <= 1'b0;
      sys_err_pulse   <= 1'b0;
      parity_seen_sts <= 1'b0;
      sys_err_sts     <= 1'b0;
    end else begin
      data_err_pulse  <= bad_data && data_err_en;
      sys_err_pulse   <= sys_fire;
      parity_seen_sts <= (bad_addr || bad_data) || (parity_seen_sts && !parity_seen_clr);
      sys_err_sts     <= sys_fire || (sys_err_sts && !sys_err_clr);
    end
  end

  // R6
  data_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_err_pulse |-> $past(data_err_en));

  // R6
  sys_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_pulse |-> $past(sys_err_en));

  // R8
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_seen_sts && !parity_seen_clr) |=> parity_seen_sts);

  // R8
  sys_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_err_sts && !sys_err_clr) |=> sys_err_sts);

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bpar_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] addr_data,
  input  logic [CMD_W-1:0]  cmd_lane,
  input  logic              chk_bit_in,
  input  logic              addr_strobe,
  input  logic              data_strobe,
  input  logic              own_drive,
  input  logic              data_err_en,
  input  logic              sys_err_en,
  input  logic              parity_seen_clr,
  input  logic              sys_err_clr,
  output logic              chk_bit_out,
  output logic              chk_bit_oe,
  output logic              data_err_pulse,
  output logic              sys_err_pulse,
  output logic              parity_seen_sts,
  output logic              sys_err_sts
);
  localparam int BUS_W = DATA_W + CMD_W;

  logic [BUS_W-1:0] bus_q;
  phase_e           kind_q;
  logic             drive_q;
  logic             gen_odd;
  logic             mismatch;

  bpar_capture #(.BUS_W(BUS_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_in      ({cmd_lane, addr_data}),
    .addr_strobe (addr_strobe),
    .data_strobe (data_strobe),
    .own_drive   (own_drive),
    .bus_q       (bus_q),
    .kind_q      (kind_q),
    .drive_q     (drive_q)
  );

  // Generated bit makes the total count of ones even.
  bpar_xor_tree #(.W(BUS_W)) u_gen (
    .bits_in (bus_q),
    .odd_out (gen_odd)
  );

  // Received bit arrives one clock after the values it covers.
  bpar_xor_tree #(.W(BUS_W + 1)) u_chk (
    .bits_in ({chk_bit_in, bus_q}),
    .odd_out (mismatch)
  );

  assign chk_bit_oe  = drive_q;
  assign chk_bit_out = drive_q & gen_odd;

  bpar_report u_rep (
    .clk             (clk),
    .rst_n           (rst_n),
    .kind_q          (kind_q),
    .mismatch        (mismatch),
    .data_err_en     (data_err_en),
    .sys_err_en      (sys_err_en),
    .parity_seen_clr (parity_seen_clr),
    .sys_err_clr     (sys_err_clr),
    .data_err_pulse  (data_err_pulse),
    .sys_err_pulse   (sys_err_pulse),
    .parity_seen_sts (parity_seen_sts),
    .sys_err_sts     (sys_err_sts)
  );

  // R1
  drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_drive |=> chk_bit_oe);

  // R3
  data_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_err_pulse |-> ($past(data_strobe, 2) && !$past(addr_strobe, 2)
                        && !$past(own_drive, 2)));

  // R5
  sys_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_pulse |-> ($past(addr_strobe, 2) && !$past(own_drive, 2)));

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !(chk_bit_oe || data_err_pulse || sys_err_pulse));

endmodule

// File: tb/sim_bus_parity_unit.sv
`timescale 1ns/1ps
module sim_bus_parity_unit;
  localparam int DW = 8;
  localparam int CW = 2;
  localparam int BW = DW + CW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] addr_data;
  logic [CW-1:0] cmd_lane;
  logic chk_bit_in, addr_strobe, data_strobe, own_drive;
  logic data_err_en, sys_err_en, parity_seen_clr, sys_err_clr;
  logic chk_bit_out, chk_bit_oe, data_err_pulse, sys_err_pulse;
  logic parity_seen_sts, sys_err_sts;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bus_parity_unit #(.DATA_W(DW), .CMD_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_data(addr_data), .cmd_lane(cmd_lane),
    .chk_bit_in(chk_bit_in), .addr_strobe(addr_strobe), .data_strobe(data_strobe),
    .own_drive(own_drive), .data_err_en(data_err_en), .sys_err_en(sys_err_en),
    .parity_seen_clr(parity_seen_clr), .sys_err_clr(sys_err_clr),
    .chk_bit_out(chk_bit_out), .chk_bit_oe(chk_bit_oe),
    .data_err_pulse(data_err_pulse), .sys_err_pulse(sys_err_pulse),
    .parity_seen_sts(parity_seen_sts), .sys_err_sts(sys_err_sts)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // One transfer: edge A samples the bus, edge B samples the parity bit.
  task automatic beat(input logic [BW-1:0] bus, input logic p, input logic a,
                      input logic d, input logic o, input logic pe, input logic se);
    logic err, dx, sx;
    string tag;
    @(negedge clk);
    {cmd_lane, addr_data} = bus;
    addr_strobe = a; data_strobe = d; own_drive = o;
    data_err_en = pe; sys_err_en = se;
    @(negedge clk);
    addr_strobe = 0; data_strobe = 0; own_drive = 0;
    chk_bit_in = p;
    addr_data = ~addr_data;
    check("R1", chk_bit_oe, o);
    if (o) check("R1", chk_bit_out, ^bus);
    @(negedge clk);
    err = ((^bus) ^ p) && !o && (a || d);
    dx  = err && !a && d && pe;
    sx  = err && a && se;
    if (o)             tag = "R7";
    else if (a && d)   tag = "R9";
    else if (!a && !d) tag = "R4";
    else if (a)        tag = se ? "R5" : "R6";
    else               tag = pe ? "R3" : "R6";
    check(tag, data_err_pulse, dx);
    check(tag, sys_err_pulse, sx);
    check("R8", parity_seen_sts, err);
    check("R8", sys_err_sts, sx);
    parity_seen_clr = 1; sys_err_clr = 1; chk_bit_in = 0;
    @(negedge clk);
    check("R3", data_err_pulse, 1'b0);
    check("R5", sys_err_pulse, 1'b0);
    check("R8", parity_seen_sts, 1'b0);
    check("R8", sys_err_sts, 1'b0);
    parity_seen_clr = 0; sys_err_clr = 0;
  endtask

  initial begin
    rst_n = 0; addr_data = '1; cmd_lane = '1; chk_bit_in = 0;
    addr_strobe = 1; data_strobe = 1; own_drive = 1;
    data_err_en = 1; sys_err_en = 1; parity_seen_clr = 0; sys_err_clr = 0;
    repeat (3) @(negedge clk);
    // R2: reset holds everything quiet
    check("R2", chk_bit_oe, 0);
    check("R2", data_err_pulse, 0);
    check("R2", sys_err_pulse, 0);
    check("R2", parity_seen_sts, 0);
    check("R2", sys_err_sts, 0);
    addr_strobe = 0; data_strobe = 0; own_drive = 0;
    rst_n = 1;
    @(negedge clk);

    // Exhaustive sweep over bus value and received parity bit.
    for (int b = 0; b < (1 << BW); b++) begin
      for (int p = 0; p < 2; p++) begin
        logic [3:0] m;
        m = 4'(b * 5 + p * 11);
        beat(BW'(b), p[0], m[0], m[1], m[3:2] == 2'd3, m[3:2] != 2'd2, m[3:2] != 2'd1);
      end
    end

    // R8: stickiness across idle cycles, then a set that coincides with a clear.
    beat(BW'(1), 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    {cmd_lane, addr_data} = BW'(3);
    addr_strobe = 1; sys_err_en = 1;
    @(negedge clk);
    addr_strobe = 0; chk_bit_in = 1;
    @(negedge clk);
    chk_bit_in = 0;
    repeat (4) @(negedge clk);
    check("R8", parity_seen_sts, 1);
    check("R8", sys_err_sts, 1);
    check("R5", sys_err_pulse, 0);
    // Clear arrives at the same edge that finds a new data error.
    {cmd_lane, addr_data} = BW'(7);
    data_strobe = 1; data_err_en = 0;
    @(negedge clk);
    data_strobe = 0; chk_bit_in = 0; parity_seen_clr = 1; sys_err_clr = 1;
    @(negedge clk);
    parity_seen_clr = 0; sys_err_clr = 0;
    check("R8", parity_seen_sts, 1);
    check("R8", sys_err_sts, 0);
    check("R6", data_err_pulse, 0);
    parity_seen_clr = 1;
    @(negedge clk);
    parity_seen_clr = 0;
    check("R8", parity_seen_sts, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule